// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the status byte of a serial flash device and rules on every command that could change the array or the status byte itself. A serial front-end hands it decoded, single-cycle command strobes together with the 21-bit target address. The guard answers each strobe one clock later with either an accept or a reject pulse. An accepted program, erase or status write raises the busy flag. The busy flag is the handshake to the array sequencer, which clears it again with a one-cycle done pulse.

Four things gate writes. The enable latch must be armed first. A three-bit protect code fences off an upper slice of the 32 sectors. A lock bit in the status byte works together with the active-low protect pin to freeze the status byte. A sleep state refuses everything except the wake command. While the busy flag is up, every command is refused and the running operation carries on unchanged. The status byte stays readable on its output at all times.

Top module: `fsr_guard`

## Requirements
- R1: After reset the status byte is 0x00, the sleep flag is low, and neither accept nor reject is asserted.
- R2: The status byte holds the busy flag in bit 0, the enable latch in bit 1, the protect code in bits 4:2 and the lock bit in bit 7; bits 6:5 always read 0. An accepted enable command sets bit 1 and an accepted disable command clears it.
- R3: Program, sector erase, bulk erase and status write are rejected, and leave the status unchanged, when the enable latch is 0.
- R4: Program and sector erase are rejected when the sector number (address bits 20:16) is protected. Code 0 protects no sector. Codes 1 to 5 protect the top 1, 2, 4, 8 and 16 sectors of 32. Codes 6 and 7 protect all sectors.
- R5: Bulk erase is accepted only when the protect code is 000.
- R6: A status write is rejected while the lock bit is 1 and the protect pin is low. With the pin high, the status write goes through.
- R7: An accepted status write loads bit 7 and bits 4:2 from its data byte, ignores the other data bits, and sets the busy flag.
- R8: An accepted program or erase sets the busy flag. A done pulse while busy clears both the busy flag and the enable latch. A done pulse while idle has no effect.
- R9: While the busy flag is set, every command is rejected and bits 7 and 4:2 of the status byte stay unchanged.
- R10: An accepted sleep command raises the sleep flag. While asleep, every command except wake is rejected. Wake is always accepted when not busy and clears the sleep flag.
- R11: Each command strobe gives exactly one accept or one reject pulse in the following cycle. A cycle with no strobe gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wren_i | input | 1 | Enable-latch set strobe |
| wrdi_i | input | 1 | Enable-latch clear strobe |
| wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Data byte for the status write |
| prog_i | input | 1 | Page program strobe |
| serase_i | input | 1 | Sector erase strobe |
| berase_i | input | 1 | Bulk erase strobe |
| sleep_i | input | 1 | Enter-sleep strobe |
| wake_i | input | 1 | Wake strobe |
| addr_i | input | ADDR_W | Target address of program and sector erase |
| wp_n_i | input | 1 | Write-protect pin, active low |
| seq_done_i | input | 1 | Sequencer completion pulse |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Command accepted, one cycle after the strobe |
| reject_o | output | 1 | Command refused, one cycle after the strobe |
| sleep_o | output | 1 | Sleep state flag |

## Verification
The assertions assume that at most one command strobe is high in any cycle, and one of them checks this assumption. They also assume that strobes are single-cycle pulses. The bench drives each command as exactly one strobe for one clock. Its random phase picks at most one command per cycle, so the assumption always holds. Done pulses are sent both while busy and while idle, which exercises the rule that an idle done pulse is ignored.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int unsigned ST_BUSY = 0;
    localparam int unsigned ST_WEL  = 1;
    localparam int unsigned ST_PROT = 2;
    localparam int unsigned ST_LOCK = 7;
    localparam int unsigned PROT_W  = 3;

    typedef enum logic [3:0] {
        RQ_NONE,
        RQ_WREN,
        RQ_WRDI,
        RQ_WRSR,
        RQ_PROG,
        RQ_SERASE,
        RQ_BERASE,
        RQ_SLEEP,
        RQ_WAKE
    } req_e;

    typedef struct packed {
        logic              lock;
        logic [PROT_W-1:0] prot;
        logic              wel;
        logic              busy;
        logic              sleep;
        logic              acc;
        logic              rej;
    } ctl_t;

    function automatic logic needs_wel(req_e r);
        return (r == RQ_WRSR) || (r == RQ_PROG) || (r == RQ_SERASE) || (r == RQ_BERASE);
    endfunction

endpackage

// File: rtl/fsr_req_enc.sv
module fsr_req_enc
    import fsr_pkg::*;
(
    input  logic wren_i,
    input  logic wrdi_i,
    input  logic wrsr_i,
    input  logic prog_i,
    input  logic serase_i,
    input  logic berase_i,
    input  logic sleep_i,
    input  logic wake_i,
    output req_e req_o,
    output logic any_o
);
    // Wake has the highest priority so that a sleeping device can always leave that state.
    always_comb begin
        req_o = RQ_NONE;
        if      (wake_i)   req_o = RQ_WAKE;
        else if (sleep_i)  req_o = RQ_SLEEP;
        else if (wrsr_i)   req_o = RQ_WRSR;
        else if (berase_i) req_o = RQ_BERASE;
        else if (serase_i) req_o = RQ_SERASE;
        else if (prog_i)   req_o = RQ_PROG;
        else if (wrdi_i)   req_o = RQ_WRDI;
        else if (wren_i)   req_o = RQ_WREN;
    end

    assign any_o = (req_o != RQ_NONE);
endmodule

// File: rtl/fsr_prot_dec.sv
module fsr_prot_dec
    import fsr_pkg::*;
#(
    parameter int unsigned SECT_W = 5
) (
    input  logic [PROT_W-1:0] code_i,
    input  logic [SECT_W-1:0] sector_i,
    output logic              hit_o
);
    localparam int unsigned N_SLICE = 5;

    // top_ones[k] is high when the sector lies in the top 2**k sectors.
    logic [N_SLICE-1:0] top_ones;

    generate
        for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
            assign top_ones[k] = &sector_i[SECT_W-1:k];
        end
    endgenerate

    always_comb begin
        hit_o = 1'b0;
        if (code_i == '0) begin
            hit_o = 1'b0;
        end else if (int'(code_i) > N_SLICE) begin
            hit_o = 1'b1;
        end else begin
            for (int k = 0; k < N_SLICE; k++) begin
                if (int'(code_i) == k + 1) hit_o = top_ones[k];
            end
        end
    end
endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
    import fsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned SECT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              prog_i,
    input  logic              serase_i,
    input  logic              berase_i,
    input  logic              sleep_i,
    input  logic              wake_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    input  logic              seq_done_i,
    output logic [7:0]        status_o,
    output logic              accept_o,
    output logic              reject_o,
    output logic              sleep_o
);
    localparam int unsigned SECT_LSB = ADDR_W - SECT_W;

    req_e              req;
    logic              any_req;
    logic              prot_hit;
    logic [SECT_W-1:0] sector;
    ctl_t              ctl_d, ctl_q;

    assign sector = addr_i[ADDR_W-1:SECT_LSB];

    fsr_req_enc u_enc (
        .wren_i   (wren_i),
        .wrdi_i   (wrdi_i),
        .wrsr_i   (wrsr_i),
        .prog_i   (prog_i),
        .serase_i (serase_i),
        .berase_i (berase_i),
        .sleep_i  (sleep_i),
        .wake_i   (wake_i),
        .req_o    (req),
        .any_o    (any_req)
    );

    fsr_prot_dec #(.SECT_W(SECT_W)) u_dec (
        .code_i   (ctl_q.prot),
        .sector_i (sector),
        .hit_o    (prot_hit)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.acc = 1'b0;
        ctl_d.rej = 1'b0;

        if (ctl_q.busy && seq_done_i) begin
            ctl_d.busy = 1'b0;
            ctl_d.wel  = 1'b0;
        end

        if (any_req) begin
            if (ctl_q.busy || (ctl_q.sleep && req != RQ_WAKE)) begin
                ctl_d.rej = 1'b1;
            end else if (needs_wel(req) && !ctl_q.wel) begin
                ctl_d.rej = 1'b1;
            end else begin
                unique case (req)
                    RQ_WREN: begin
                        ctl_d.acc = 1'b1;
                        ctl_d.wel = 1'b1;
                    end
                    RQ_WRDI: begin
                        ctl_d.acc = 1'b1;
                        ctl_d.wel = 1'b0;
                    end
                    RQ_SLEEP: begin
                        ctl_d.acc   = 1'b1;
                        ctl_d.sleep = 1'b1;
                    end
                    RQ_WAKE: begin
                        ctl_d.acc   = 1'b1;
                        ctl_d.sleep = 1'b0;
                    end
                    RQ_WRSR: begin
                        if (ctl_q.lock && !wp_n_i) begin
                            ctl_d.rej = 1'b1;
                        end else begin
                            ctl_d.acc  = 1'b1;
                            ctl_d.lock = wrsr_data_i[ST_LOCK];
                            ctl_d.prot = wrsr_data_i[ST_PROT +: PROT_W];
                            ctl_d.busy = 1'b1;
                        end
                    end
                    RQ_PROG, RQ_SERASE: begin
                        if (prot_hit) begin
                            ctl_d.rej = 1'b1;
                        end else begin
                            ctl_d.acc  = 1'b1;
                            ctl_d.busy = 1'b1;
                        end
                    end
                    RQ_BERASE: begin
                        if (ctl_q.prot != '0) begin
                            ctl_d.rej = 1'b1;
                        end else begin
                            ctl_d.acc  = 1'b1;
                            ctl_d.busy = 1'b1;
                        end
                    end
                    default: ctl_d.rej = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign status_o = {ctl_q.lock, 2'b00, ctl_q.prot, ctl_q.wel, ctl_q.busy};
    assign accept_o = ctl_q.acc;
    assign reject_o = ctl_q.rej;
    assign sleep_o  = ctl_q.sleep;

    // R11
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_i, wrdi_i, wrsr_i, prog_i, serase_i, berase_i, sleep_i, wake_i}));
    // R11
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> (accept_o ^ reject_o));
    // R11
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (!accept_o && !reject_o));
    // R3
    no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_i || serase_i || berase_i || wrsr_i) && !status_o[ST_WEL]) |=> reject_o);
    // R4
    prot_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_i || serase_i) && prot_hit) |=> reject_o);
    // R5
    bulk_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (berase_i && status_o[4:2] != 3'b000) |=> reject_o);
    // R6
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_i && status_o[ST_LOCK] && !wp_n_i) |=> (reject_o && $stable(status_o[7:2])));
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_BUSY] && seq_done_i) |=> (!status_o[ST_BUSY] && !status_o[ST_WEL]));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_BUSY] && any_req) |=> (reject_o && $stable({status_o[7], status_o[4:2]})));
    // R10
    sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && any_req && !wake_i) |=> (reject_o && sleep_o));
endmodule

// File: tb/fsr_guard_tb.sv
module fsr_guard_tb;
    localparam int CLK_T = 10;
    localparam int K_WREN = 1, K_WRDI = 2, K_WRSR = 3, K_PROG = 4, K_SERASE = 5,
                   K_BERASE = 6, K_SLEEP = 7, K_WAKE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wren = 0, wrdi = 0, wrsr = 0, prog = 0, serase = 0, berase = 0, sleep = 0, wake = 0;
    logic [7:0]  wdata = '0;
    logic [20:0] addr = '0;
    logic wp_n = 1'b1;
    logic done = 1'b0;
    logic [7:0] status;
    logic acc, rej, slp;

    int total = 0;
    int bad = 0;
    string phase = "R1";

    always #(CLK_T/2) clk = ~clk;

    fsr_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
        .wrsr_data_i(wdata), .prog_i(prog), .serase_i(serase), .berase_i(berase),
        .sleep_i(sleep), .wake_i(wake), .addr_i(addr), .wp_n_i(wp_n),
        .seq_done_i(done), .status_o(status), .accept_o(acc), .reject_o(rej),
        .sleep_o(slp)
    );

    // behavioural reference
    bit m_busy, m_wel, m_sleep, m_lock, m_acc, m_rej;
    int m_prot;

    function automatic bit ref_prot(int code, int sec);
        if (code == 0) return 1'b0;
        if (code >= 6) return 1'b1;
        return sec >= (32 - (1 << (code - 1)));
    endfunction

    function automatic logic [7:0] m_status();
        logic [2:0] p;
        p = m_prot[2:0];
        return {m_lock, 2'b00, p, m_wel, m_busy};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_wel = 0; m_sleep = 0; m_lock = 0; m_prot = 0; m_acc = 0; m_rej = 0;
        end else begin
            bit any;
            bit was_busy;
            any = wren | wrdi | wrsr | prog | serase | berase | sleep | wake;
            was_busy = m_busy;
            m_acc = 0; m_rej = 0;
            if (was_busy && done) begin m_busy = 0; m_wel = 0; end
            if (any) begin
                if (was_busy) m_rej = 1;
                else if (m_sleep && !wake) m_rej = 1;
                else if (wake) begin m_acc = 1; m_sleep = 0; end
                else if (sleep) begin m_acc = 1; m_sleep = 1; end
                else if (wren) begin m_acc = 1; m_wel = 1; end
                else if (wrdi) begin m_acc = 1; m_wel = 0; end
                else if (!m_wel) m_rej = 1;
                else if (wrsr) begin
                    if (m_lock && !wp_n) m_rej = 1;
                    else begin
                        m_acc = 1; m_lock = wdata[7]; m_prot = int'(wdata[4:2]); m_busy = 1;
                    end
                end else if (berase) begin
                    if (m_prot != 0) m_rej = 1;
                    else begin m_acc = 1; m_busy = 1; end
                end else begin
                    if (ref_prot(m_prot, int'(addr[20:16]))) m_rej = 1;
                    else begin m_acc = 1; m_busy = 1; end
                end
            end
        end
    end

    // compare every clock, a quarter period after the edge
    always begin
        @(posedge clk);
        #(CLK_T/4);
        if (rst_n) begin
            total++;
            if (status !== m_status() || acc !== m_acc || rej !== m_rej || slp !== m_sleep) begin
                bad++;
                $display("FAIL %s cycle compare: got st=%h acc=%b rej=%b slp=%b exp st=%h acc=%b rej=%b slp=%b",
                         phase, status, acc, rej, slp, m_status(), m_acc, m_rej, m_sleep);
            end
        end
    end

    task automatic chk(string tag, logic [7:0] es, logic ea, logic er, logic esl);
        total++;
        if (status !== es || acc !== ea || rej !== er || slp !== esl) begin
            bad++;
            $display("FAIL %s: got st=%h acc=%b rej=%b slp=%b exp st=%h acc=%b rej=%b slp=%b",
                     tag, status, acc, rej, slp, es, ea, er, esl);
        end
    endtask

    task automatic issue(int kind, logic [7:0] d, int sec);
        @(negedge clk);
        wdata = d;
        addr = {sec[4:0], 16'h1234};
        case (kind)
            K_WREN:   wren = 1;
            K_WRDI:   wrdi = 1;
            K_WRSR:   wrsr = 1;
            K_PROG:   prog = 1;
            K_SERASE: serase = 1;
            K_BERASE: berase = 1;
            K_SLEEP:  sleep = 1;
            K_WAKE:   wake = 1;
            default: ;
        endcase
        @(negedge clk);
        {wren, wrdi, wrsr, prog, serase, berase, sleep, wake} = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done = 1;
        @(negedge clk);
        done = 0;
    endtask

    initial begin
        #(CLK_T*150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        phase = "R1";
        chk("R1 reset", 8'h00, 0, 0, 0);

        phase = "R3";
        issue(K_PROG, 8'h00, 0);    chk("R3 prog no latch", 8'h00, 0, 1, 0);
        issue(K_BERASE, 8'h00, 0);  chk("R3 bulk no latch", 8'h00, 0, 1, 0);
        issue(K_WRSR, 8'hFF, 0);    chk("R3 wrsr no latch", 8'h00, 0, 1, 0);
        issue(K_SERASE, 8'h00, 3);  chk("R3 serase no latch", 8'h00, 0, 1, 0);

        phase = "R2";
        issue(K_WREN, 8'h00, 0);    chk("R2 enable", 8'h02, 1, 0, 0);
        issue(K_WRDI, 8'h00, 0);    chk("R2 disable", 8'h00, 1, 0, 0);

        phase = "R7";
        issue(K_WREN, 8'h00, 0);
        issue(K_WRSR, 8'hFF, 0);    chk("R7 wrsr load", 8'h9F, 1, 0, 0);
        pulse_done();               chk("R8 done clears", 8'h9C, 0, 0, 0);

        phase = "R9";
        issue(K_WREN, 8'h00, 0);
        issue(K_WRSR, 8'h00, 0);    chk("R9 setup", 8'h03, 1, 0, 0);
        issue(K_WREN, 8'h00, 0);    chk("R9 busy wren", 8'h03, 0, 1, 0);
        issue(K_WRDI, 8'h00, 0);    chk("R9 busy wrdi", 8'h03, 0, 1, 0);
        pulse_done();               chk("R9 release", 8'h00, 0, 0, 0);

        phase = "R6";
        issue(K_WREN, 8'h00, 0);
        issue(K_WRSR, 8'h84, 0);
        pulse_done();               chk("R6 locked", 8'h84, 0, 0, 0);
        wp_n = 0;
        issue(K_WREN, 8'h00, 0);    chk("R6 wren", 8'h86, 1, 0, 0);
        issue(K_WRSR, 8'h00, 0);    chk("R6 hw lock", 8'h86, 0, 1, 0);
        wp_n = 1;
        issue(K_WRSR, 8'h00, 0);    chk("R6 pin high", 8'h03, 1, 0, 0);
        pulse_done();               chk("R6 cleared", 8'h00, 0, 0, 0);

        phase = "R5";
        issue(K_WREN, 8'h00, 0);
        issue(K_WRSR, 8'h04, 0);
        pulse_done();
        issue(K_WREN, 8'h00, 0);
        issue(K_BERASE, 8'h00, 0);  chk("R5 bulk protected", 8'h06, 0, 1, 0);
        issue(K_WRSR, 8'h00, 0);
        pulse_done();
        issue(K_WREN, 8'h00, 0);
        issue(K_BERASE, 8'h00, 0);  chk("R5 bulk open", 8'h03, 1, 0, 0);
        pulse_done();

        phase = "R8";
        pulse_done();               chk("R8 idle done", 8'h00, 0, 0, 0);
        issue(K_WREN, 8'h00, 0);
        pulse_done();               chk("R8 idle done keeps latch", 8'h02, 0, 0, 0);
        issue(K_PROG, 8'h00, 5);    chk("R8 prog busy", 8'h03, 1, 0, 0);
        pulse_done();               chk("R8 prog done", 8'h00, 0, 0, 0);

        phase = "R4";
        for (int code = 0; code < 8; code++) begin
            issue(K_WREN, 8'h00, 0);
            issue(K_WRSR, 8'(code << 2), 0);
            pulse_done();
            for (int s = 0; s < 32; s++) begin
                bit p;
                p = ref_prot(code, s);
                issue(K_WREN, 8'h00, 0);
                issue((s % 2 == 0) ? K_PROG : K_SERASE, 8'h00, s);
                chk("R4 sector gate", {3'b000, code[2:0], 1'b1, !p}, !p, p, 0);
                if (p) issue(K_WRDI, 8'h00, 0);
                else pulse_done();
            end
        end
        issue(K_WREN, 8'h00, 0);
        issue(K_WRSR, 8'h00, 0);
        pulse_done();

        phase = "R10";
        issue(K_SLEEP, 8'h00, 0);   chk("R10 enter", 8'h00, 1, 0, 1);
        issue(K_WREN, 8'h00, 0);    chk("R10 wren blocked", 8'h00, 0, 1, 1);
        issue(K_PROG, 8'h00, 0);    chk("R10 prog blocked", 8'h00, 0, 1, 1);
        issue(K_SLEEP, 8'h00, 0);   chk("R10 sleep blocked", 8'h00, 0, 1, 1);
        issue(K_WAKE, 8'h00, 0);    chk("R10 wake", 8'h00, 1, 0, 0);
        issue(K_WAKE, 8'h00, 0);    chk("R10 wake awake", 8'h00, 1, 0, 0);

        phase = "R11";
        @(negedge clk);             chk("R11 quiet", 8'h00, 0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            int k;
            @(negedge clk);
            {wren, wrdi, wrsr, prog, serase, berase, sleep, wake} = '0;
            k = $urandom_range(0, 12);
            wdata = 8'($urandom);
            addr = 21'($urandom);
            wp_n = ($urandom_range(0, 3) != 0);
            done = ($urandom_range(0, 4) == 0);
            case (k)
                1, 9, 10: wren = 1;
                2:  wrdi = 1;
                3:  wrsr = 1;
                4, 11: prog = 1;
                5:  serase = 1;
                6:  berase = 1;
                7:  sleep = 1;
                8, 12: wake = 1;
                default: ;
            endcase
        end
        @(negedge clk);
        {wren, wrdi, wrsr, prog, serase, berase, sleep, wake} = '0;
        done = 0;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule